// File: doc/BRIEF.md
# System clock mode controller

This block holds the 8-bit CPU mode register that decides how the system clock phi is produced, and it produces phi as a stream of one-cycle clock-enable pulses. The fast main oscillator is the block's own clock `clk`. The ring oscillator arrives as a one-cycle enable tick `ring_tick`. Software writes the register to choose the phi source and division ratio, to start or stop each oscillator, to set the oscillation type and to select the stack page. It can read the register back at any time.

The ratio field can pick main/1, main/2, main/8 or the ring oscillator. A new ratio takes effect only when the current phi period ends, so a switch never produces a short period. If the selected source is stopped, phi pulses stop and the block does not fall back to another source. The oscillation-type bit can be written once after reset. If RC mode is locked in, any main-clock ratio is replaced by main/8 and a flag reports the illegal setting.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x80 (ratio field = ring source, every other bit 0). `osc_rc`, `stack_page` and `ratio_err` are 0, and phi follows the ring oscillator.
- R2: In ceramic mode (bit 3 = 0) with the main oscillator running, the ratio field in bits 7:6 sets the spacing of `phi_en` pulses: 11 gives a pulse every cycle, 00 every 2 cycles and 01 every 8 cycles.
- R3: With ratio field 10 and the ring oscillator running, `phi_en` pulses exactly once, one cycle after each `ring_tick` pulse.
- R4: Bit 5 = 1 stops the main oscillator and bit 4 = 1 stops the ring oscillator. When the selected source is stopped, `phi_en` stays 0.
- R5: Bit 3 (0 ceramic, 1 RC) takes the value from the first register write after reset. Later writes leave it unchanged until a reset, which re-arms it.
- R6: Bits 1:0 (processor mode) always read 00. Writes of the reserved codes 01, 10 and 11 are ignored.
- R7: Bit 2 is stored, read back and driven on `stack_page`.
- R8: A ratio change while phi runs from the main clock takes effect only after the current period has completed. Every gap between pulses equals either the old or the new period.
- R9: If RC mode is set and the ratio field holds 00 or 11, phi runs at main/8 and `ratio_err` is 1. If the ratio field selects the ring source, `ratio_err` is 0.
- R10: `main_run` is the inverse of bit 5 and `ring_run` is the inverse of bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| ring_tick | input | 1 | One-cycle tick from the ring oscillator |
| rd_data | output | 8 | Register readback |
| phi_en | output | 1 | phi clock-enable pulse |
| stack_page | output | 1 | Selected stack page |
| osc_rc | output | 1 | Oscillation type, 1 = RC |
| main_run | output | 1 | Main oscillator enable |
| ring_run | output | 1 | Ring oscillator enable |
| ratio_err | output | 1 | RC mode combined with a main-clock ratio |

## Verification
An internal fault shows up directly at the ports. A wrong active ratio changes the spacing of `phi_en` within one period, at most 8 cycles. A wrong lock state shows in `rd_data` bit 3 on the write that follows. A ratio loaded at the wrong moment leaves one pulse gap that matches neither the old nor the new period, and the gap check catches it during the switch. A stopped source that still produces pulses is caught within a single measurement window.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;
  typedef enum logic [1:0] {
    SEL_HALF   = 2'b00,
    SEL_EIGHTH = 2'b01,
    SEL_RING   = 2'b10,
    SEL_FULL   = 2'b11
  } div_sel_e;
endpackage

// File: rtl/clk_mode_regs.sv
module clk_mode_regs
  import clk_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output div_sel_e   eff_sel,
  output logic       stack_page,
  output logic       osc_rc,
  output logic       main_run,
  output logic       ring_run,
  output logic       ratio_err
);
  div_sel_e div_q;
  logic     main_stop_q, ring_stop_q, rc_q, stack_q, lock_q, err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q       <= SEL_RING;
      main_stop_q <= 1'b0;
      ring_stop_q <= 1'b0;
      rc_q        <= 1'b0;
      stack_q     <= 1'b0;
      lock_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      if (wr_en) begin
        div_q       <= div_sel_e'(wr_data[7:6]);
        main_stop_q <= wr_data[5];
        ring_stop_q <= wr_data[4];
        stack_q     <= wr_data[2];
        if (!lock_q) rc_q <= wr_data[3];
        lock_q      <= 1'b1;
      end
      err_q <= rc_q && (div_q != SEL_RING);
    end
  end

  always_comb begin
    if (div_q == SEL_RING)  eff_sel = SEL_RING;
    else if (rc_q)          eff_sel = SEL_EIGHTH;
    else                    eff_sel = div_q;
  end

  assign rd_data    = {div_q, main_stop_q, ring_stop_q, rc_q, stack_q, 2'b00};
  assign stack_page = stack_q;
  assign osc_rc     = rc_q;
  assign main_run   = !main_stop_q;
  assign ring_run   = !ring_stop_q;
  assign ratio_err  = err_q;

  p_lock_hold_r5: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(rc_q));
  p_err_needs_rc_r9: assert property (@(posedge clk) disable iff (rst)
    err_q |-> rc_q);
endmodule

// File: rtl/clk_mode_div.sv
module clk_mode_div
  import clk_mode_pkg::*;
#(
  parameter int DIV_FULL   = 1,
  parameter int DIV_HALF   = 2,
  parameter int DIV_EIGHTH = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  div_sel_e eff_sel,
  input  logic     main_run,
  input  logic     ring_run,
  input  logic     ring_tick,
  output logic     phi_en
);
  localparam int MAXDIV = (DIV_EIGHTH > DIV_HALF) ? DIV_EIGHTH : DIV_HALF;
  localparam int CW     = $clog2(MAXDIV + 1);

  div_sel_e      active_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_cnt;
  logic          is_ring, main_tick, boundary, phi_q;

  always_comb begin
    case (active_q)
      SEL_FULL:   last_cnt = CW'(DIV_FULL - 1);
      SEL_HALF:   last_cnt = CW'(DIV_HALF - 1);
      default:    last_cnt = CW'(DIV_EIGHTH - 1);
    endcase
  end

  assign is_ring   = (active_q == SEL_RING);
  assign main_tick = !is_ring && main_run && (cnt_q == last_cnt);
  assign boundary  = is_ring || !main_run || main_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= SEL_RING;
      cnt_q    <= '0;
      phi_q    <= 1'b0;
    end else begin
      phi_q <= is_ring ? (ring_run && ring_tick) : main_tick;
      if (boundary) begin
        active_q <= eff_sel;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign phi_en = phi_q;

  p_wrap_only_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(active_q) |-> $past(boundary));
  p_src_alive_r4: assert property (@(posedge clk) disable iff (rst)
    (!is_ring && !main_run) |=> !phi_q);
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(MAXDIV - 1));
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_mode_pkg::*;
#(
  parameter int DIV_FULL   = 1,
  parameter int DIV_HALF   = 2,
  parameter int DIV_EIGHTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       ring_tick,
  output logic [7:0] rd_data,
  output logic       phi_en,
  output logic       stack_page,
  output logic       osc_rc,
  output logic       main_run,
  output logic       ring_run,
  output logic       ratio_err
);
  div_sel_e eff_sel;

  clk_mode_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .eff_sel(eff_sel), .stack_page(stack_page),
    .osc_rc(osc_rc), .main_run(main_run), .ring_run(ring_run),
    .ratio_err(ratio_err)
  );

  clk_mode_div #(.DIV_FULL(DIV_FULL), .DIV_HALF(DIV_HALF), .DIV_EIGHTH(DIV_EIGHTH)) u_div (
    .clk(clk), .rst(rst), .eff_sel(eff_sel), .main_run(main_run),
    .ring_run(ring_run), .ring_tick(ring_tick), .phi_en(phi_en)
  );

  p_mode_bits_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[1:0] == 2'b00));
  p_rc_forced_r9: assert property (@(posedge clk) disable iff (rst)
    (osc_rc && rd_data[7:6] != 2'b10 && $past(osc_rc) && $past(rd_data[7:6]) != 2'b10) |-> ratio_err);
endmodule

// File: tb/sim_clk_mode_ctrl.sv
module sim_clk_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       ring_tick = 1'b0;
  logic [7:0] rd_data;
  logic       phi_en, stack_page, osc_rc, main_run, ring_run, ratio_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_pulse = -1;
  int gap_bad = 0;
  int pulses = 0;
  int gap_a = 0;
  int gap_b = 0;
  bit done = 1'b0;

  clk_mode_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ring_tick(ring_tick),
    .rd_data(rd_data), .phi_en(phi_en), .stack_page(stack_page), .osc_rc(osc_rc),
    .main_run(main_run), .ring_run(ring_run), .ratio_err(ratio_err)
  );

  always #2 clk = ~clk;

  // ring tick every 5th cycle, pulse monitor with gap checking
  always @(negedge clk) begin
    cyc <= cyc + 1;
    ring_tick <= ((cyc % 5) == 0);
    if (phi_en) begin
      pulses <= pulses + 1;
      if (last_pulse >= 0 && (cyc - last_pulse) != gap_a && (cyc - last_pulse) != gap_b)
        gap_bad <= gap_bad + 1;
      last_pulse <= cyc;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // settle, then observe pulse spacing; expect gap g (0 = no pulses)
  task automatic measure(input string req, input int g);
    repeat (20) @(negedge clk);
    gap_a = g; gap_b = g; last_pulse = -1; pulses = 0; gap_bad = 0;
    repeat (80) @(negedge clk);
    if (g == 0) check(req, pulses, 0);
    else begin
      check(req, gap_bad, 0);
      check(req, (pulses >= 80 / g - 1) ? 1 : 0, 1);
    end
  endtask

  initial begin
    repeat (2000) @(negedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R1 rd_data", rd_data, 8'h80);
    check("R1 osc_rc", osc_rc, 0);
    check("R1 stack", stack_page, 0);
    check("R1 ratio_err", ratio_err, 0);
    measure("R1 R3 ring gap", 5);

    wr(8'hC0);
    check("R5 first write", rd_data, 8'hC0);
    measure("R2 div1", 1);
    wr(8'hCB);
    check("R5 R6 lock and mode bits", rd_data, 8'hC0);
    wr(8'hC4);
    check("R7 readback", rd_data, 8'hC4);
    check("R7 stack_page", stack_page, 1);
    wr(8'h00);
    measure("R2 div2", 2);
    wr(8'h40);
    measure("R2 div8", 8);

    // R8: switch /8 -> /2 at arbitrary phases
    for (int k = 0; k < 8; k++) begin
      wr(8'h40);
      repeat (20 + k) @(negedge clk);
      gap_a = 8; gap_b = 2; last_pulse = -1; gap_bad = 0;
      wr(8'h00);
      repeat (30) @(negedge clk);
      check("R8 no short period", gap_bad, 0);
    end

    wr(8'h20);
    check("R10 main_run", main_run, 0);
    measure("R4 main stopped", 0);
    wr(8'h90);
    check("R10 ring_run", ring_run, 0);
    check("R10 main_run back", main_run, 1);
    measure("R4 ring stopped", 0);
    wr(8'h80);
    measure("R3 ring again", 5);

    do_reset();
    wr(8'h08);
    check("R5 rearm", osc_rc, 1);
    measure("R9 forced div8 from 00", 8);
    check("R9 ratio_err", ratio_err, 1);
    wr(8'hC0);
    check("R5 lock holds RC", rd_data[3], 1);
    measure("R9 forced div8 from 11", 8);
    check("R9 ratio_err 11", ratio_err, 1);
    wr(8'h80);
    measure("R9 ring with RC", 5);
    check("R9 ratio_err ring", ratio_err, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule